// File: doc/BRIEF.md
# Serial Pixel Link Transmitter

This block sends one camera frame across a two-lane serial pixel link. After a frame request it first streams a variable-length header, one bit per clock and most significant bit first, on a lane reserved for that purpose. Then it places digitized pixels on a separate video lane. Three strobes frame the video: one covers the whole frame, one covers each line and one marks the data bits of each pixel. The link clock is the block's own clock, forwarded unchanged. All lanes and strobes change on its rising edge.

Pixels move at a fixed cadence of one 20-clock slot per pixel, which gives 2 Mpixel/s at a 40 MHz bit clock. In each slot the 14 sample bits go first, and then 6 idle clocks follow. Pixels come from a valid/ready stream. When the stream is empty at the start of a slot, the slot is filled with zeros and a sticky underrun flag is set, so the frame timing is never stretched. The header is read from an external byte buffer through an address output. Line length and line count are sampled when a frame starts. Both the full 2048-pixel-line geometry and the half-frame geometry fit the 12-bit fields.

The controller has five states:
- `ST_IDLE` waits for a request.
- `ST_HDR` shifts out the header.
- `ST_GAP` is a single quiet clock before video.
- `ST_LINE` sends pixel slots with the line strobe high.
- `ST_LGAP` is one slot with the line strobe low between lines.

Its transitions are:
- Idle to header on start with a nonzero length.
- Idle to gap on start with zero length.
- Header to gap after the last header bit.
- Gap to line.
- Line to line-gap at the end of a line that is not the last.
- Line-gap to line after one slot.
- Line to idle at the end of the last line.

Top module: `pix_link_tx`

## Requirements
- R1: While reset is held low, and after it is released with no frame requested, `hdr_lane`, `vid_lane`, `fval`, `lval`, `dval`, `busy`, `pix_ready` and `underrun` are all 0.
- R2: A `start` sampled high while idle begins a frame. Header bit j (j = 0 .. 8·L−1, where L is `hdr_len`) appears on `hdr_lane` from the j-th rising edge after the one that samples `start`, counting that edge as the 0th. Bit j is bit 7−(j mod 8) of buffer byte j/8, with bytes read upward from address 0. Lengths above 256 are treated as 256. `hdr_lane` is 0 outside the header.
- R3: `fval` rises exactly 8·L+1 edges after the start edge, so a length of 0 skips the header and `fval` rises one edge after start.
- R4: Each pixel slot lasts 20 clocks. For the first 14 clocks `dval` is 1 and `vid_lane` carries the sample, MSB first. For the last 6 clocks `dval` is 0. `vid_lane` is 0 whenever `dval` is 0.
- R5: `pix_ready` is 1 exactly in the clock before each slot begins. A pixel is taken when `pix_valid` and `pix_ready` are both 1.
- R6: If `pix_valid` is 0 while `pix_ready` is 1, the slot sends 14 zero bits with normal strobes and `underrun` becomes 1. `underrun` stays 1 until the next accepted `start` clears it.
- R7: `lval` is high for `line_len` slots per line and low for exactly one slot between lines. `fval` is high from the first slot to the end of the last slot of the last line, then falls together with `lval` and `busy`.
- R8: Line length and line count are captured at the start edge. Changes during a frame have no effect. A value of 0 is treated as 1.
- R9: `start` is ignored while `busy` is 1.
- R10: `link_clk` is identical to `clk`.
- R11: A 2048-pixel line is accepted and takes exactly 2048·20 clocks of `fval` for one line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock (40 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame request, sampled while idle |
| hdr_len | input | 9 | Header length in bytes (0..256) |
| hdr_addr | output | 8 | Header buffer read address |
| hdr_data | input | 8 | Header byte at `hdr_addr` (combinational read) |
| line_len | input | 12 | Pixels per line |
| line_count | input | 12 | Lines per frame |
| pix_valid | input | 1 | Pixel stream valid |
| pix_data | input | 14 | Pixel sample |
| pix_ready | output | 1 | Pixel taken at the next edge when valid |
| link_clk | output | 1 | Forwarded bit clock |
| hdr_lane | output | 1 | Serial header lane |
| vid_lane | output | 1 | Serial video lane |
| fval | output | 1 | Frame strobe |
| lval | output | 1 | Line strobe |
| dval | output | 1 | Data-bit strobe |
| busy | output | 1 | Frame in progress |
| underrun | output | 1 | Sticky pixel underrun flag |

## Verification
A wrong state or counter shows up at the ports within at most one slot. An off-by-one in the slot counter changes the number of `dval` bits per pixel and moves the `pix_ready` pulse, which the first decoded pixel exposes. A wrong pixel or line index changes the count of `lval` cycles and the length of `fval`, which is measured at the end of each frame. A wrong header byte or bit index corrupts the header bits, which are compared bit by bit from the very first edge after start.

// File: rtl/pl_pkg.sv
package pl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_HDR  = 3'd1,
        ST_GAP  = 3'd2,
        ST_LINE = 3'd3,
        ST_LGAP = 3'd4
    } lnk_state_t;
endpackage

// File: rtl/pl_hdr_ser.sv
module pl_hdr_ser #(
    parameter int HDR_MAX = 256
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              load,
    input  logic                              run,
    input  logic [$clog2(HDR_MAX+1)-1:0]      len_in,
    input  logic [7:0]                        byte_in,
    output logic [$clog2(HDR_MAX)-1:0]        rd_addr,
    output logic                              bit_out,
    output logic                              last
);
    localparam int LEN_W  = $clog2(HDR_MAX + 1);
    localparam int ADDR_W = $clog2(HDR_MAX);

    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] byte_idx;
    logic [LEN_W-1:0] nxt_idx;
    logic [LEN_W-1:0] len_c;
    logic [2:0]       bit_idx;
    logic [7:0]       sr;

    // lengths above the maximum are clamped
    assign len_c   = (len_in > LEN_W'(HDR_MAX)) ? LEN_W'(HDR_MAX) : len_in;
    assign nxt_idx = byte_idx + LEN_W'(1);
    // while idle the buffer is addressed at byte 0 so it is ready at start
    assign rd_addr = run ? nxt_idx[ADDR_W-1:0] : '0;
    assign bit_out = run & sr[7];
    assign last    = run && (bit_idx == 3'd7) && (byte_idx == len_q - LEN_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q    <= '0;
            byte_idx <= '0;
            bit_idx  <= '0;
            sr       <= '0;
        end else if (load) begin
            len_q    <= len_c;
            byte_idx <= '0;
            bit_idx  <= '0;
            sr       <= byte_in;
        end else if (run) begin
            bit_idx <= bit_idx + 3'd1;
            if (bit_idx == 3'd7) begin
                sr       <= byte_in;
                byte_idx <= nxt_idx;
            end else begin
                sr <= {sr[6:0], 1'b0};
            end
        end else begin
            byte_idx <= '0;
            bit_idx  <= '0;
        end
    end
endmodule

// File: rtl/pl_pix_ser.sv
module pl_pix_ser #(
    parameter int PIX_W     = 14,
    parameter int SLOT_CLKS = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic             active,
    input  logic             clear,
    input  logic             pix_valid,
    input  logic [PIX_W-1:0] pix_data,
    output logic             slot_end,
    output logic             dval,
    output logic             vid,
    output logic             underrun
);
    localparam int CNT_W = $clog2(SLOT_CLKS);

    logic [CNT_W-1:0] cnt;
    logic [PIX_W-1:0] sr;

    assign slot_end = run && (cnt == CNT_W'(SLOT_CLKS - 1));
    assign dval     = active && (cnt < CNT_W'(PIX_W));
    assign vid      = dval & sr[PIX_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= (cnt == CNT_W'(SLOT_CLKS - 1)) ? '0 : cnt + CNT_W'(1);
        end else begin
            cnt <= '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (load) begin
            sr <= pix_valid ? pix_data : '0;
        end else if (active) begin
            sr <= {sr[PIX_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            underrun <= 1'b0;
        end else if (clear) begin
            underrun <= 1'b0;
        end else if (load && !pix_valid) begin
            underrun <= 1'b1;
        end
    end
endmodule

// File: rtl/pl_frame_fsm.sv
module pl_frame_fsm
    import pl_pkg::*;
#(
    parameter int LPIX_W = 12,
    parameter int LCNT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              hdr_nonzero,
    input  logic              hdr_last,
    input  logic              slot_end,
    input  logic [LPIX_W-1:0] line_len,
    input  logic [LCNT_W-1:0] line_count,
    output lnk_state_t        state,
    output logic              accept,
    output logic              load,
    output logic              fval,
    output logic              lval,
    output logic              busy
);
    lnk_state_t        nxt;
    logic [LPIX_W-1:0] len_q;
    logic [LCNT_W-1:0] cnt_q;
    logic [LPIX_W-1:0] pix_idx;
    logic [LCNT_W-1:0] line_idx;
    logic              line_end;
    logic              frame_end;

    assign accept    = (state == ST_IDLE) && start;
    assign line_end  = (pix_idx == len_q - LPIX_W'(1));
    assign frame_end = line_end && (line_idx == cnt_q - LCNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start) nxt = hdr_nonzero ? ST_HDR : ST_GAP;
            ST_HDR:  if (hdr_last) nxt = ST_GAP;
            ST_GAP:  nxt = ST_LINE;
            ST_LINE: if (slot_end && line_end) nxt = frame_end ? ST_IDLE : ST_LGAP;
            ST_LGAP: if (slot_end) nxt = ST_LINE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q    <= LPIX_W'(1);
            cnt_q    <= LCNT_W'(1);
            pix_idx  <= '0;
            line_idx <= '0;
        end else if (accept) begin
            len_q    <= (line_len == '0)   ? LPIX_W'(1) : line_len;
            cnt_q    <= (line_count == '0) ? LCNT_W'(1) : line_count;
            pix_idx  <= '0;
            line_idx <= '0;
        end else if (state == ST_LINE && slot_end) begin
            pix_idx <= line_end ? '0 : pix_idx + LPIX_W'(1);
        end else if (state == ST_LGAP && slot_end) begin
            line_idx <= line_idx + LCNT_W'(1);
        end
    end

    always_comb begin
        fval = 1'b0;
        lval = 1'b0;
        busy = 1'b1;
        load = 1'b0;
        unique case (state)
            ST_IDLE: busy = 1'b0;
            ST_HDR:  ;
            ST_GAP:  load = 1'b1;
            ST_LINE: begin
                fval = 1'b1;
                lval = 1'b1;
                load = slot_end && !line_end;
            end
            ST_LGAP: begin
                fval = 1'b1;
                load = slot_end;
            end
            default: busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/pix_link_tx.sv
module pix_link_tx
    import pl_pkg::*;
#(
    parameter int PIX_W     = 14,
    parameter int SLOT_CLKS = 20,
    parameter int HDR_MAX   = 256,
    parameter int LPIX_W    = 12,
    parameter int LCNT_W    = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [$clog2(HDR_MAX+1)-1:0]  hdr_len,
    output logic [$clog2(HDR_MAX)-1:0]    hdr_addr,
    input  logic [7:0]                    hdr_data,
    input  logic [LPIX_W-1:0]             line_len,
    input  logic [LCNT_W-1:0]             line_count,
    input  logic                          pix_valid,
    input  logic [PIX_W-1:0]              pix_data,
    output logic                          pix_ready,
    output logic                          link_clk,
    output logic                          hdr_lane,
    output logic                          vid_lane,
    output logic                          fval,
    output logic                          lval,
    output logic                          dval,
    output logic                          busy,
    output logic                          underrun
);
    lnk_state_t state;
    logic       accept;
    logic       load;
    logic       hdr_last;
    logic       slot_end;
    logic       hdr_nonzero;

    assign link_clk    = clk;
    assign hdr_nonzero = (hdr_len != '0);
    assign pix_ready   = load;

    pl_frame_fsm #(
        .LPIX_W (LPIX_W),
        .LCNT_W (LCNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .hdr_nonzero (hdr_nonzero),
        .hdr_last    (hdr_last),
        .slot_end    (slot_end),
        .line_len    (line_len),
        .line_count  (line_count),
        .state       (state),
        .accept      (accept),
        .load        (load),
        .fval        (fval),
        .lval        (lval),
        .busy        (busy)
    );

    pl_hdr_ser #(
        .HDR_MAX (HDR_MAX)
    ) u_hdr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept && hdr_nonzero),
        .run     (state == ST_HDR),
        .len_in  (hdr_len),
        .byte_in (hdr_data),
        .rd_addr (hdr_addr),
        .bit_out (hdr_lane),
        .last    (hdr_last)
    );

    pl_pix_ser #(
        .PIX_W     (PIX_W),
        .SLOT_CLKS (SLOT_CLKS)
    ) u_pix (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .run       (state == ST_LINE || state == ST_LGAP),
        .active    (state == ST_LINE),
        .clear     (accept),
        .pix_valid (pix_valid),
        .pix_data  (pix_data),
        .slot_end  (slot_end),
        .dval      (dval),
        .vid       (vid_lane),
        .underrun  (underrun)
    );
endmodule

// File: rtl/pl_link_chk.sv
module pl_link_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic pix_valid,
    input logic pix_ready,
    input logic hdr_lane,
    input logic vid_lane,
    input logic fval,
    input logic lval,
    input logic dval,
    input logic busy,
    input logic underrun
);
    // R4
    vid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dval |-> !vid_lane);

    // R7
    dval_in_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dval |-> (lval && fval));

    // R7
    lval_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lval |-> fval);

    // R2
    hdr_before_video_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_lane |-> (!fval && busy));

    // R5
    slot_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dval) |-> $past(pix_ready));

    // R5
    ready_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ready |-> busy);

    // R6
    underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !(start && !busy)) |=> underrun);

    // R6
    underrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> $past(pix_ready && !pix_valid));

    // R7
    frame_opens_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fval) |-> lval);
endmodule

bind pix_link_tx pl_link_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .pix_valid (pix_valid),
    .pix_ready (pix_ready),
    .hdr_lane  (hdr_lane),
    .vid_lane  (vid_lane),
    .fval      (fval),
    .lval      (lval),
    .dval      (dval),
    .busy      (busy),
    .underrun  (underrun)
);

// File: tb/pix_link_tx_tb.sv
`timescale 1ns/1ps
module pix_link_tx_tb;
    localparam int CLK_PERIOD = 25;
    localparam int NVEC = 5;

    typedef struct packed {
        logic [8:0]  hl;
        logic [11:0] ll;
        logic [11:0] lc;
        logic [15:0] dly;
        logic [31:0] flen;
    } vec_t;

    // header length, line length, line count, fval delay (8L+1), fval length
    localparam vec_t VECS [NVEC] = '{
        '{9'd3, 12'd2, 12'd2, 16'd25, 32'd100},
        '{9'd0, 12'd3, 12'd1, 16'd1,  32'd60},
        '{9'd1, 12'd1, 12'd3, 16'd9,  32'd100},
        '{9'd2, 12'd4, 12'd2, 16'd17, 32'd180},
        '{9'd5, 12'd1, 12'd1, 16'd41, 32'd20}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [8:0]  hdr_len = '0;
    logic [7:0]  hdr_addr;
    logic [7:0]  hdr_data;
    logic [11:0] line_len = '0;
    logic [11:0] line_count = '0;
    logic        pix_valid;
    logic [13:0] pix_data;
    logic        pix_ready, link_clk, hdr_lane, vid_lane;
    logic        fval, lval, dval, busy, underrun;

    int   errors = 0;
    int   checks = 0;
    int   src_n = 0;
    logic src_en = 1'b1;
    logic [7:0] hbuf [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [13:0] pixval(int n);
        return 14'((n * 1237 + 91) & 16'h3FFF);
    endfunction

    assign hdr_data  = hbuf[hdr_addr];
    assign pix_valid = src_en;
    assign pix_data  = pixval(src_n);

    always @(posedge clk) if (pix_valid && pix_ready) src_n <= src_n + 1;

    pix_link_tx u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .hdr_len(hdr_len),
        .hdr_addr(hdr_addr), .hdr_data(hdr_data), .line_len(line_len),
        .line_count(line_count), .pix_valid(pix_valid), .pix_data(pix_data),
        .pix_ready(pix_ready), .link_clk(link_clk), .hdr_lane(hdr_lane),
        .vid_lane(vid_lane), .fval(fval), .lval(lval), .dval(dval),
        .busy(busy), .underrun(underrun)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic run_frame(input int hl, input int ll, input int lc,
                             input int exp_dly, input int exp_flen,
                             input bit disturb, input bit exp_under);
        int hl_c, ll_c, lc_c, k, first_f, flen, lhigh, lrise, rdy, dcnt;
        int npix, nb, pix_err, hdr_err, vid_err, base;
        bit prev_l, rdy_gap, under0;
        logic [13:0] word;
        hl_c = (hl > 256) ? 256 : hl;
        ll_c = (ll == 0) ? 1 : ll;
        lc_c = (lc == 0) ? 1 : lc;
        first_f = -1; flen = 0; lhigh = 0; lrise = 0; rdy = 0; dcnt = 0;
        npix = 0; nb = 0; pix_err = 0; hdr_err = 0; vid_err = 0;
        prev_l = 1'b0; rdy_gap = 1'b0; word = '0; under0 = 1'b0;
        @(negedge clk);
        hdr_len = 9'(hl); line_len = 12'(ll); line_count = 12'(lc); start = 1'b1;
        base = src_n;
        @(negedge clk);
        start = 1'b0;
        k = 0;
        while (1) begin
            if (k < 8 * hl_c) begin
                if (hdr_lane !== hbuf[k/8][7 - (k % 8)]) hdr_err++;
            end else if (hdr_lane !== 1'b0) hdr_err++;
            if (k == 0) under0 = underrun;
            if (fval && first_f < 0) first_f = k;
            if (fval) flen++;
            if (lval) lhigh++;
            if (lval && !prev_l) lrise++;
            prev_l = lval;
            if (pix_ready) rdy++;
            if (k == 8 * hl_c) rdy_gap = pix_ready;
            if (dval) begin
                dcnt++;
                word = {word[12:0], vid_lane};
                nb++;
                if (nb == 14) begin
                    if (word !== (src_en ? pixval(base + npix) : 14'd0)) pix_err++;
                    npix++;
                    nb = 0;
                end
            end else if (vid_lane !== 1'b0) vid_err++;
            if (disturb && k == 5) begin
                // R8 / R9: geometry change and second start mid-frame
                start = 1'b1; line_len = 12'd7; line_count = 12'd5; hdr_len = 9'd9;
            end else start = 1'b0;
            if (!busy || k > 120000) break;
            k++;
            @(negedge clk);
        end
        start = 1'b0;
        chk(hdr_err == 0, "R2", "header bit mismatches", hdr_err, 0);
        chk(first_f == exp_dly, "R3", "fval rise delay", first_f, exp_dly);
        chk(flen == exp_flen, "R7", "fval length", flen, exp_flen);
        chk(lhigh == ll_c * lc_c * 20, "R7", "lval high clocks", lhigh, ll_c * lc_c * 20);
        chk(lrise == lc_c, "R7", "line count", lrise, lc_c);
        chk(dcnt == 14 * ll_c * lc_c, "R4", "dval clocks", dcnt, 14 * ll_c * lc_c);
        chk(npix == ll_c * lc_c && pix_err == 0, "R4", "pixel mismatches", pix_err, 0);
        chk(vid_err == 0, "R4", "video high with dval low", vid_err, 0);
        chk(rdy == ll_c * lc_c, "R5", "ready pulses", rdy, ll_c * lc_c);
        chk(rdy_gap == 1'b1, "R5", "ready before first slot", int'(rdy_gap), 1);
        chk(under0 == 1'b0, "R6", "underrun after start", int'(under0), 0);
        chk(underrun == exp_under, "R6", "underrun at end", int'(underrun), int'(exp_under));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: timeout actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) hbuf[i] = 8'((i * 37 + 5) & 255);
        // R1: reset state
        repeat (3) @(negedge clk);
        chk({hdr_lane, vid_lane, fval, lval, dval, busy, pix_ready, underrun} == 8'h00,
            "R1", "outputs in reset", 0, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk({hdr_lane, vid_lane, fval, lval, dval, busy, pix_ready, underrun} == 8'h00,
            "R1", "outputs idle after reset", 0, 0);
        // R10: forwarded clock
        chk(link_clk == 1'b0, "R10", "link_clk low phase", int'(link_clk), 0);
        @(posedge clk); #1;
        chk(link_clk == 1'b1, "R10", "link_clk high phase", int'(link_clk), 1);

        // table of geometries (R2 R3 R4 R5 R7)
        for (int v = 0; v < NVEC; v++)
            run_frame(int'(VECS[v].hl), int'(VECS[v].ll), int'(VECS[v].lc),
                      int'(VECS[v].dly), int'(VECS[v].flen), 1'b0, 1'b0);

        // R8 R9: mid-frame start and geometry change have no effect
        run_frame(1, 2, 2, 9, 100, 1'b1, 1'b0);
        // R8: zero geometry treated as one
        run_frame(0, 0, 0, 1, 20, 1'b0, 1'b0);
        // R6: empty pixel stream gives zero slots and a sticky flag
        src_en = 1'b0;
        run_frame(0, 2, 1, 1, 40, 1'b0, 1'b1);
        repeat (5) @(negedge clk);
        chk(underrun == 1'b1, "R6", "underrun held while idle", int'(underrun), 1);
        src_en = 1'b1;
        run_frame(1, 1, 1, 9, 20, 1'b0, 1'b0);
        // R11 and R2 clamp: 2048-pixel line, header length 300 treated as 256
        run_frame(300, 2048, 1, 2049, 40960, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule